// File: doc/BRIEF.md
# Ping-Pong Acquisition Buffer Sequencer

This block steers a stream of 16-bit samples into two memory buffers that take turns. For every accepted sample it gives a buffer select and a word address. Each time the active buffer fills, it raises a one-cycle interrupt and continues on the other buffer. Software can therefore drain one buffer while the other one fills.

A start pulse latches a total transfer length in bytes and a continuous-mode flag. In counted mode the block splits the total into whole buffers of fixed capacity and then one shorter final buffer that holds the leftover bytes. When the last buffer fills, it raises done. In continuous mode full buffers alternate without end. A stop request ends the run at the next buffer boundary.

Top module: `pingpong_seq`

## Requirements
- R1: After reset, busy_o, done_o, irq_o and wr_en_o are low, and buf_sel_o and wr_addr_o are 0.
- R2: A start_i pulse while busy_o is low latches total_bytes_i and continuous_i, sets busy_o, selects buffer 0 and sets the address to 0. A start_i pulse while busy_o is high has no effect.
- R3: While busy_o is high, each sample_valid_i cycle asserts wr_en_o and writes at wr_addr_o. The address then advances by one word, unless that write fills the buffer.
- R4: buf_len_o gives the active buffer length in bytes. For the first counted buffer it is BUF_BYTES when total_bytes_i is at least BUF_BYTES, and otherwise the total itself.
- R5: The cycle after the write into the last word of a buffer, irq_o is high for that one cycle, buf_sel_o toggles and wr_addr_o returns to 0. buf_sel_o changes at no other time, except that an accepted start sets it to 0.
- R6: A counted run fills floor(total/BUF_BYTES) full buffers. If there is a remainder, one final buffer of remainder bytes follows the full buffers.
- R7: When the remainder is zero, no empty buffer is armed, and done_o rises together with the irq of the last full buffer. A counted start with fewer than 2 bytes raises done_o on the next cycle, with no buffer and no interrupt.
- R8: In continuous mode every buffer is BUF_BYTES long, and done_o stays low until a stop is requested.
- R9: A stop_i pulse during a run lets the current buffer fill completely, and done_o rises with that buffer's irq. A stop_i pulse while idle is ignored.
- R10: done_o stays high and busy_o stays low until the next accepted start. While busy_o is low, sample_valid_i does not assert wr_en_o and does not move wr_addr_o.
- R11: Bit 0 of total_bytes_i is ignored, so an odd byte count is rounded down to whole 16-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; latches length and mode |
| total_bytes_i | input | LEN_W | Total transfer length in bytes (counted mode) |
| continuous_i | input | 1 | 1 selects endless alternation, with no end count |
| stop_i | input | 1 | Stop request, honoured at the next buffer boundary |
| sample_valid_i | input | 1 | One 16-bit sample is present this cycle |
| wr_en_o | output | 1 | Write strobe for the sample |
| buf_sel_o | output | 1 | Active buffer index (0 or 1) |
| wr_addr_o | output | $clog2(BUF_BYTES/2) | Word address inside the active buffer |
| buf_len_o | output | $clog2(BUF_BYTES)+1 | Active buffer length in bytes |
| irq_o | output | 1 | One-cycle pulse after a buffer fills |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | The run has completed |

## Verification
The assertions check the following on every cycle:
- every interrupt coincides with a buffer-select toggle, and the select is stable otherwise;
- the address stays inside the active length, steps by one word per write and holds when there is no write;
- writes occur only while busy, and busy and done are never high together;
- done can rise only with an interrupt or directly after a start.

Only the bench scenarios can show the buffer sequence itself: how many full buffers a total produces, the shortened final buffer, skipping a zero remainder, an odd byte count, and a stop that lets the current buffer complete. The scoreboard predicts these from the total and compares every write and every interrupt.

// File: rtl/pingpong_pkg.sv
`timescale 1ns/1ps
package pingpong_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } pp_state_e;
endpackage

// File: rtl/pingpong_plan.sv
`timescale 1ns/1ps
// Splits a byte total into full-buffer runs and a remainder run.
module pingpong_plan #(
  parameter int unsigned LEN_W     = 24,
  parameter int unsigned BUF_BYTES = 16384,
  localparam int unsigned LOG_BUF  = $clog2(BUF_BYTES),
  localparam int unsigned WORDS    = BUF_BYTES / 2,
  localparam int unsigned WW       = $clog2(WORDS) + 1,
  localparam int unsigned QW       = LEN_W - LOG_BUF,
  localparam int unsigned RUN_W    = QW + 1
) (
  input  logic [LEN_W-1:0]        total_i,
  output logic signed [RUN_W-1:0] runs_o,
  output logic [WW-1:0]           last_words_o,
  output logic [WW-1:0]           first_words_o
);
  logic [QW-1:0] quot;
  logic          unused_lsb;

  assign unused_lsb   = total_i[0];
  assign quot         = total_i[LEN_W-1:LOG_BUF];
  assign runs_o       = $signed({1'b0, quot}) - RUN_W'(1);
  assign last_words_o = {1'b0, total_i[LOG_BUF-1:1]};
  assign first_words_o = (quot != '0) ? WW'(WORDS) : last_words_o;
endmodule

// File: rtl/pingpong_addr.sv
`timescale 1ns/1ps
// Word address counter for the active buffer.
module pingpong_addr #(
  parameter int unsigned AW = 13,
  localparam int unsigned WW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          adv_i,
  input  logic [WW-1:0] len_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;

  assign last_o = ({1'b0, addr_q} + WW'(1)) == len_i;
  assign addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 addr_q <= '0;
    else if (clear_i)            addr_q <= '0;
    else if (adv_i && last_o)    addr_q <= '0;
    else if (adv_i)              addr_q <= addr_q + AW'(1);
  end
endmodule

// File: rtl/pingpong_ctrl.sv
`timescale 1ns/1ps
// Run counting, buffer switching and completion.
module pingpong_ctrl
  import pingpong_pkg::*;
#(
  parameter int unsigned WORDS = 8192,
  parameter int unsigned RUN_W = 11,
  localparam int unsigned WW   = $clog2(WORDS) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    cont_i,
  input  logic                    stop_i,
  input  logic                    fill_i,
  input  logic signed [RUN_W-1:0] runs_i,
  input  logic [WW-1:0]           last_words_i,
  input  logic [WW-1:0]           first_words_i,
  output pp_state_e               state_o,
  output logic                    accept_o,
  output logic                    sel_o,
  output logic [WW-1:0]           words_o,
  output logic                    irq_o
);
  localparam logic [WW-1:0] FULL = WW'(WORDS);

  pp_state_e               state_q;
  logic                    cont_q, stop_q, sel_q, irq_q;
  logic signed [RUN_W-1:0] runs_q;
  logic [WW-1:0]           last_q, words_q;
  logic [WW-1:0]           next_words;
  logic                    finish;

  assign accept_o = start_i && (state_q != ST_RUN);

  // Decide what the next buffer gets when the current one fills.
  always_comb begin
    next_words = FULL;
    finish     = 1'b0;
    if (stop_q || stop_i) begin
      finish = 1'b1;
    end else if (!cont_q) begin
      if (runs_q >= 0) begin
        if (runs_q != 0)        next_words = FULL;
        else if (last_q == '0)  finish = 1'b1;
        else                    next_words = last_q;
      end else begin
        finish = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cont_q  <= 1'b0;
      stop_q  <= 1'b0;
      sel_q   <= 1'b0;
      irq_q   <= 1'b0;
      runs_q  <= '0;
      last_q  <= '0;
      words_q <= FULL;
    end else begin
      irq_q <= 1'b0;
      if (accept_o) begin
        cont_q <= cont_i;
        stop_q <= 1'b0;
        runs_q <= runs_i;
        last_q <= last_words_i;
        sel_q  <= 1'b0;
        if (!cont_i && first_words_i == '0) begin
          state_q <= ST_DONE;
        end else begin
          state_q <= ST_RUN;
          words_q <= cont_i ? FULL : first_words_i;
        end
      end else if (state_q == ST_RUN) begin
        if (stop_i) stop_q <= 1'b1;
        if (fill_i) begin
          irq_q <= 1'b1;
          sel_q <= ~sel_q;
          if (!cont_q) runs_q <= runs_q - RUN_W'(1);
          if (finish) state_q <= ST_DONE;
          else        words_q <= next_words;
        end
      end
    end
  end

  assign state_o = state_q;
  assign sel_o   = sel_q;
  assign words_o = words_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/pingpong_seq.sv
`timescale 1ns/1ps
module pingpong_seq
  import pingpong_pkg::*;
#(
  parameter int unsigned LEN_W     = 24,
  parameter int unsigned BUF_BYTES = 16384,
  localparam int unsigned LOG_BUF  = $clog2(BUF_BYTES),
  localparam int unsigned WORDS    = BUF_BYTES / 2,
  localparam int unsigned AW       = $clog2(WORDS),
  localparam int unsigned WW       = AW + 1,
  localparam int unsigned RUN_W    = LEN_W - LOG_BUF + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] total_bytes_i,
  input  logic             continuous_i,
  input  logic             stop_i,
  input  logic             sample_valid_i,
  output logic             wr_en_o,
  output logic             buf_sel_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [WW:0]      buf_len_o,
  output logic             irq_o,
  output logic             busy_o,
  output logic             done_o
);
  logic signed [RUN_W-1:0] runs;
  logic [WW-1:0]           last_words, first_words, cur_words;
  logic                    accept, last_word, fill;
  pp_state_e               state;

  pingpong_plan #(.LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) u_plan (
    .total_i       (total_bytes_i),
    .runs_o        (runs),
    .last_words_o  (last_words),
    .first_words_o (first_words)
  );

  pingpong_ctrl #(.WORDS(WORDS), .RUN_W(RUN_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .cont_i        (continuous_i),
    .stop_i        (stop_i),
    .fill_i        (fill),
    .runs_i        (runs),
    .last_words_i  (last_words),
    .first_words_i (first_words),
    .state_o       (state),
    .accept_o      (accept),
    .sel_o         (buf_sel_o),
    .words_o       (cur_words),
    .irq_o         (irq_o)
  );

  pingpong_addr #(.AW(AW)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .adv_i   (wr_en_o),
    .len_i   (cur_words),
    .addr_o  (wr_addr_o),
    .last_o  (last_word)
  );

  assign busy_o    = (state == ST_RUN);
  assign done_o    = (state == ST_DONE);
  assign wr_en_o   = busy_o && sample_valid_i;
  assign fill      = wr_en_o && last_word;
  assign buf_len_o = {cur_words, 1'b0};
endmodule

// File: rtl/pingpong_seq_chk.sv
`timescale 1ns/1ps
module pingpong_seq_chk #(
  parameter int unsigned BUF_BYTES = 16384,
  localparam int unsigned AW = $clog2(BUF_BYTES / 2),
  localparam int unsigned WW = AW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          wr_en_o,
  input logic          buf_sel_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [WW:0]   buf_len_o,
  input logic          irq_o,
  input logic          busy_o,
  input logic          done_o
);
  assert_irq_toggles_sel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (buf_sel_o != $past(buf_sel_o)));

  assert_sel_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !$past(start_i)) |-> $stable(buf_sel_o));

  assert_addr_in_buf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ({1'b0, wr_addr_o} < buf_len_o[WW:1]));

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_o) && !irq_o) |-> (wr_addr_o == $past(wr_addr_o) + AW'(1)));

  assert_addr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_o) && !$past(start_i)) |-> $stable(wr_addr_o));

  assert_wr_only_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);

  assert_done_busy_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  assert_len_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (buf_len_o != '0 && buf_len_o <= (WW+1)'(BUF_BYTES)));

  assert_done_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (irq_o || $past(start_i)));
endmodule

bind pingpong_seq pingpong_seq_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .wr_en_o   (wr_en_o),
  .buf_sel_o (buf_sel_o),
  .wr_addr_o (wr_addr_o),
  .buf_len_o (buf_len_o),
  .irq_o     (irq_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/pingpong_seq_bench.sv
`timescale 1ns/1ps
module pingpong_seq_bench;
  localparam int LEN_W = 12;
  localparam int BUF_BYTES = 16;
  localparam int WORDS = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, cont, stop, valid;
  logic [LEN_W-1:0] total;
  logic wr_en, buf_sel, irq, busy, done;
  logic [AW-1:0] wr_addr;
  logic [AW+1:0] buf_len;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  logic [AW:0] wq[$];
  logic [1:0]  iq[$];

  always #2.5 clk = ~clk;

  pingpong_seq #(.LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) u_pingpong_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .total_bytes_i(total),
    .continuous_i(cont), .stop_i(stop), .sample_valid_i(valid),
    .wr_en_o(wr_en), .buf_sel_o(buf_sel), .wr_addr_o(wr_addr),
    .buf_len_o(buf_len), .irq_o(irq), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard: expected writes and interrupts of one buffer.
  task automatic expect_buf(input int b, input int len, input bit fin);
    for (int a = 0; a < len; a++) wq.push_back({b[0], a[AW-1:0]});
    iq.push_back({~b[0], fin});
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (wq.size() == 0) chk(1'b0, {tag, " unexpected write"}, 1, 0);
        else begin
          logic [AW:0] e;
          e = wq.pop_front();
          chk({buf_sel, wr_addr} == e, {tag, " write sel/addr"}, int'({buf_sel, wr_addr}), int'(e));
        end
      end
      if (irq) begin
        if (iq.size() == 0) chk(1'b0, {tag, " unexpected irq"}, 1, 0);
        else begin
          logic [1:0] e;
          e = iq.pop_front();
          chk({buf_sel, done} == e, {tag, " irq sel/done"}, int'({buf_sel, done}), int'(e));
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_start(input int t, input bit c);
    start = 1'b1; total = t[LEN_W-1:0]; cont = c;
    tick();
    start = 1'b0;
  endtask

  task automatic feed(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      valid = 1'b1;
      tick();
      if (gap > 0) begin
        valid = 1'b0;
        repeat (gap) tick();
      end
    end
    valid = 1'b0;
  endtask

  task automatic finish_check(input string req);
    repeat (2) tick();
    chk(done && !busy, {req, " done at end"}, int'({done, busy}), 2);
    chk(wq.size() == 0 && iq.size() == 0, {req, " all expected items seen"},
        wq.size() + iq.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    start = 0; cont = 0; stop = 0; valid = 0; total = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(!busy && !done, "R1 busy/done low", int'({busy, done}), 0);
    chk(!irq && !wr_en, "R1 irq/wr_en low", int'({irq, wr_en}), 0);
    chk(buf_sel == 0 && wr_addr == 0, "R1 sel/addr zero", int'({buf_sel, wr_addr}), 0);

    // R6: 40 bytes -> 8, 8, 4 words; R2 start while busy ignored
    tag = "R6";
    do_start(40, 0);
    chk(buf_len == 16, "R4 first len full", int'(buf_len), 16);
    chk(busy, "R2 busy after start", int'(busy), 1);
    expect_buf(0, 8, 0); expect_buf(1, 8, 0); expect_buf(2, 4, 1);
    feed(5, 0);
    do_start(2, 0);
    chk(busy && wr_addr == 5, "R2 start while busy ignored", int'(wr_addr), 5);
    feed(11, 1);
    chk(buf_len == 8, "R6 remainder len", int'(buf_len), 8);
    feed(4, 0);
    finish_check("R6");

    // R4: total below a buffer
    tag = "R4";
    do_start(10, 0);
    chk(buf_len == 10, "R4 short first len", int'(buf_len), 10);
    expect_buf(0, 5, 1);
    feed(5, 2);
    finish_check("R4");

    // R7: exact multiple, no empty buffer; R2 sel reset on start
    tag = "R7";
    do_start(32, 0);
    chk(buf_sel == 0, "R2 sel reset by start", int'(buf_sel), 0);
    expect_buf(0, 8, 0); expect_buf(1, 8, 1);
    feed(16, 0);
    finish_check("R7");

    // R7: tiny total, done without buffer or irq
    do_start(1, 0);
    chk(done && !busy, "R7 tiny total done", int'({done, busy}), 2);
    repeat (2) tick();

    // R11: odd count 21 -> 10 words -> 8 + 2
    tag = "R11";
    do_start(21, 0);
    expect_buf(0, 8, 0); expect_buf(1, 2, 1);
    feed(10, 0);
    finish_check("R11");

    // R10: samples ignored while idle; R9 stop while idle ignored
    tag = "R10";
    valid = 1'b1;
    #1;
    chk(!wr_en, "R10 no write while idle", int'(wr_en), 0);
    tick();
    valid = 1'b0;
    chk(wr_addr == 0 && done, "R10 addr held, done held", int'({done, wr_addr}), 8);
    stop = 1'b1; tick(); stop = 1'b0;
    tag = "R9";
    do_start(16, 0);
    expect_buf(0, 8, 1);
    feed(8, 0);
    finish_check("R9 idle stop ignored");

    // R8 continuous, then R9 stop mid-buffer without truncation
    tag = "R8";
    do_start(0, 1);
    chk(buf_len == 16, "R8 full len in continuous", int'(buf_len), 16);
    expect_buf(0, 8, 0); expect_buf(1, 8, 0); expect_buf(2, 8, 0); expect_buf(3, 8, 1);
    feed(24, 0);
    tick();
    chk(busy && !done, "R8 still running", int'({busy, done}), 2);
    tag = "R9";
    feed(3, 0);
    stop = 1'b1; tick(); stop = 1'b0;
    chk(busy, "R9 busy after stop", int'(busy), 1);
    feed(5, 0);
    finish_check("R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule